// File: doc/BRIEF.md
# Serial Receiver Status Flag Unit

This block holds the error and status flags of an asynchronous serial receiver and presents them to a processor as two read-only status registers and one data register. A separate receiver core, outside this block, samples the line and reports each character through single-cycle event strobes: noise seen, bad stop bit, parity mismatch, break, byte ready, start edge, false start and idle line. The block turns these strobes into sticky flags and keeps the last received byte. It also raises interrupt requests for the three error flags, each gated by its own enable input.

Software clears a flag in two steps. It first reads the status register that holds the flag while the flag is set. It then reads the data register. A flag that sets after the status read survives the following data read. The break flag also has a re-arm guard: once a break has been reported, another break is not flagged until the line has been seen idle high.

Top module: `rx_flag_unit`

## Requirements
- R1: After a synchronous active-low reset, every flag, the break guard and the ninth received bit are 0, both status registers read 0x00 and all interrupt outputs are low.
- R2: Register map on `bus_addr`: 0 = status A, 1 = status B, 2 = data, 3 reads 0x00. Status A holds parity error in bit 0, framing error in bit 1, noise in bit 2 and receive-data-full in bit 5, with all other bits 0. Each of the parity, framing and noise strobes sets its flag. The byte-ready strobe sets receive-data-full.
- R3: Each of `irq_noise`, `irq_frame` and `irq_parity` is high exactly while its flag is set and its enable input is high.
- R4: A flag clears only when a read of its status register (a cycle with `bus_rd` high) finds it set and a later read of the data register follows. A data read with no such prior status read leaves every flag unchanged.
- R5: A flag that was clear at the status read and sets before the following data read stays set after that data read.
- R6: If a set strobe and a clearing data read hit the same flag in the same cycle, the flag ends up set.
- R7: A break strobe sets the break flag, the framing flag and the receive-data-full flag. With `mode9` high it also clears `rx_bit9`. A break raises no interrupt output of its own.
- R8: After a break has been flagged, a further break strobe sets no break flag until `line_high` has been seen for at least one cycle. Another break after that sets the flag again.
- R9: Status B holds the break flag in bit 1 and reception-in-progress in bit 0, with bits 7 to 2 reading 0. The start strobe sets reception-in-progress. The false-start or idle strobe clears it. Reading has no effect on it.
- R10: A data register read returns the byte from the last byte-ready strobe. A write to address 2 loads `tx_data`. Reset changes neither.
- R11: A read of status B with the break flag set, followed by a data read, clears the break flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_noise | input | 1 | Noise seen on the current character |
| ev_frame | input | 1 | Stop bit sampled low |
| ev_parity | input | 1 | Parity mismatch |
| ev_break | input | 1 | Break character detected |
| ev_ready | input | 1 | Received byte available on rx_data |
| ev_start | input | 1 | Low sample at the first start-bit search point |
| ev_false | input | 1 | Start bit rejected |
| ev_idle | input | 1 | Idle character detected |
| line_high | input | 1 | Receive line observed high |
| rx_data | input | 8 | Received byte, valid with ev_ready |
| rx_in9 | input | 1 | Received ninth bit, valid with ev_ready |
| mode9 | input | 1 | Nine-bit character mode |
| en_noise | input | 1 | Noise interrupt enable |
| en_frame | input | 1 | Framing interrupt enable |
| en_parity | input | 1 | Parity interrupt enable |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| tx_data | output | 8 | Byte to transmit |
| rx_bit9 | output | 1 | Received ninth bit |
| irq_noise | output | 1 | Noise interrupt request |
| irq_frame | output | 1 | Framing interrupt request |
| irq_parity | output | 1 | Parity interrupt request |

## Verification
The clearing sequence is tried four ways: a data read with no status read before it, a status read then a data read, a status read with a new event before the data read, and an event in the same cycle as the data read. These separate a correct snapshot-based clear from a plain clear-on-data-read and from a clear that loses a same-cycle set. Break strobes are sent with and without an idle-high line between them, which separates a working re-arm guard from none. Reception-in-progress is driven through start, false-start and idle strobes. A reset in the middle of the run shows that the data and transmit bytes survive it while the flags do not.

// File: rtl/rxf_pkg.sv
// Package: shared constants for the receiver status flag unit.
// Assumes an 8-bit data bus and a 2-bit register address.
package rxf_pkg;
    localparam int DW = 8;
    localparam int AW = 2;

    // Register addresses
    localparam logic [AW-1:0] ADDR_STAT_A = 2'd0;
    localparam logic [AW-1:0] ADDR_STAT_B = 2'd1;
    localparam logic [AW-1:0] ADDR_DATA   = 2'd2;

    // Index of each flag in the status-A flag vector
    localparam int FI_PARITY = 0;
    localparam int FI_FRAME  = 1;
    localparam int FI_NOISE  = 2;
    localparam int FI_FULL   = 3;
    localparam int NFLAGS_A  = 4;

    // Bit positions in the status-A read value
    localparam int SA_PARITY = 0;
    localparam int SA_FRAME  = 1;
    localparam int SA_NOISE  = 2;
    localparam int SA_FULL   = 5;
endpackage

// File: rtl/rxf_flag_cell.sv
// Module: one sticky status flag with a two-step clear.
// A snapshot strobe (the status read) arms the clear only if the flag is set
// at that moment; the next clear strobe (the data read) then drops the flag.
// A set strobe always wins over a clear in the same cycle.
// Assumes the snapshot and clear strobes never occur in the same cycle.
module rxf_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic snap_i,
    input  logic clr_i,
    output logic flag_o
);
    logic armed_q;

    // Flag state: set has priority, armed clear next, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (set_i) begin
            flag_o <= 1'b1;
        end else if (clr_i && armed_q) begin
            flag_o <= 1'b0;
        end
    end

    // Arming: capture the flag at the snapshot, disarm on the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (snap_i) begin
            armed_q <= flag_o;
        end else if (clr_i) begin
            armed_q <= 1'b0;
        end
    end
endmodule

// File: rtl/rxf_break_guard.sv
// Module: break re-arm guard.
// Once a break strobe arrives, further breaks are masked until the line has
// been observed high. A break and a line-high in the same cycle leave the
// guard closed (the break is the later event on the line).
module rxf_break_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic brk_i,
    input  logic line_high_i,
    output logic accept_o
);
    logic blocked_q;

    // Guard state: close on a break, reopen on an idle-high line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blocked_q <= 1'b0;
        end else if (brk_i) begin
            blocked_q <= 1'b1;
        end else if (line_high_i) begin
            blocked_q <= 1'b0;
        end
    end

    // Accept a break only while the guard is open.
    always_comb accept_o = brk_i && !blocked_q;
endmodule

// File: rtl/rx_flag_unit.sv
// Module: status flag unit of an asynchronous serial receiver.
// Collects one-cycle event strobes from a receiver core into sticky flags,
// exposes them in two read-only status registers next to a data register,
// and drives enable-gated error interrupts.
// Assumes all strobes are synchronous to clk and one cycle wide, and that a
// byte-ready strobe and a break strobe never coincide.
module rx_flag_unit #(
    parameter int DW = rxf_pkg::DW,
    parameter int AW = rxf_pkg::AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_noise,
    input  logic          ev_frame,
    input  logic          ev_parity,
    input  logic          ev_break,
    input  logic          ev_ready,
    input  logic          ev_start,
    input  logic          ev_false,
    input  logic          ev_idle,
    input  logic          line_high,
    input  logic [DW-1:0] rx_data,
    input  logic          rx_in9,
    input  logic          mode9,
    input  logic          en_noise,
    input  logic          en_frame,
    input  logic          en_parity,
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic [DW-1:0] tx_data,
    output logic          rx_bit9,
    output logic          irq_noise,
    output logic          irq_frame,
    output logic          irq_parity
);
    import rxf_pkg::*;

    logic                snap_a, snap_b, data_rd;
    logic [NFLAGS_A-1:0] set_a;
    logic [NFLAGS_A-1:0] flags_a;
    logic                noise_f, frame_f, parity_f, full_f;
    logic                brk_accept, break_f;
    logic                rip_q;
    logic [DW-1:0]       rx_buf_q;

    // Bus decode of the read strobes that drive the clear sequence.
    always_comb begin
        snap_a  = bus_rd && (bus_addr == ADDR_STAT_A);
        snap_b  = bus_rd && (bus_addr == ADDR_STAT_B);
        data_rd = bus_rd && (bus_addr == ADDR_DATA);
    end

    // Set sources of the status-A flags; a break also marks framing and full.
    always_comb begin
        set_a            = '0;
        set_a[FI_PARITY] = ev_parity;
        set_a[FI_FRAME]  = ev_frame || ev_break;
        set_a[FI_NOISE]  = ev_noise;
        set_a[FI_FULL]   = ev_ready || ev_break;
    end

    // One flag cell per status-A flag.
    for (genvar gi = 0; gi < NFLAGS_A; gi++) begin : g_flag_a
        rxf_flag_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_a[gi]),
            .snap_i (snap_a),
            .clr_i  (data_rd),
            .flag_o (flags_a[gi])
        );
    end

    always_comb begin
        parity_f = flags_a[FI_PARITY];
        frame_f  = flags_a[FI_FRAME];
        noise_f  = flags_a[FI_NOISE];
        full_f   = flags_a[FI_FULL];
    end

    rxf_break_guard u_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .brk_i       (ev_break),
        .line_high_i (line_high),
        .accept_o    (brk_accept)
    );

    rxf_flag_cell u_break (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (brk_accept),
        .snap_i (snap_b),
        .clr_i  (data_rd),
        .flag_o (break_f)
    );

    // Reception in progress: set by a start edge, dropped by false start or idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rip_q <= 1'b0;
        end else if (ev_start) begin
            rip_q <= 1'b1;
        end else if (ev_false || ev_idle) begin
            rip_q <= 1'b0;
        end
    end

    // Ninth bit: loaded with each byte, cleared by a break in nine-bit mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_bit9 <= 1'b0;
        end else if (ev_ready) begin
            rx_bit9 <= rx_in9;
        end else if (ev_break && mode9) begin
            rx_bit9 <= 1'b0;
        end
    end

    // Data buffers: not reset, so their contents survive a reset.
    always_ff @(posedge clk) begin
        if (ev_ready) begin
            rx_buf_q <= rx_data;
        end
        if (bus_wr && (bus_addr == ADDR_DATA)) begin
            tx_data <= bus_wdata;
        end
    end

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_STAT_A: begin
                bus_rdata[SA_PARITY] = parity_f;
                bus_rdata[SA_FRAME]  = frame_f;
                bus_rdata[SA_NOISE]  = noise_f;
                bus_rdata[SA_FULL]   = full_f;
            end
            ADDR_STAT_B: bus_rdata[1:0] = {break_f, rip_q};
            ADDR_DATA:   bus_rdata = rx_buf_q;
            default:     bus_rdata = '0;
        endcase
    end

    // Enable-gated error interrupts; break and progress flags never interrupt.
    always_comb begin
        irq_noise  = noise_f  && en_noise;
        irq_frame  = frame_f  && en_frame;
        irq_parity = parity_f && en_parity;
    end
endmodule

// File: rtl/rxf_checker.sv
// Module: protocol checker for rx_flag_unit, attached by bind.
// Assumes the same synchronous active-low reset as the unit it watches.
module rxf_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ev_noise,
    input logic       ev_break,
    input logic       ev_start,
    input logic       ev_false,
    input logic       ev_idle,
    input logic       bus_rd,
    input logic [1:0] bus_addr,
    input logic       noise_f,
    input logic       frame_f,
    input logic       full_f,
    input logic       rip_q,
    input logic       en_noise,
    input logic       irq_noise
);
    // R6: a set strobe always leaves the flag set, even against a clear.
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ev_noise |=> noise_f);

    // R7: a break marks the framing and full flags.
    a_r7_break_side: assert property (@(posedge clk) disable iff (!rst_n)
        ev_break |=> (frame_f && full_f));

    // R9: a start edge raises reception in progress.
    a_r9_rip_set: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start |=> rip_q);

    // R9: false start or idle drops reception in progress.
    a_r9_rip_clr: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_false || ev_idle) && !ev_start) |=> !rip_q);

    // R4: only a data read can take a set flag down.
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (noise_f && !(bus_rd && bus_addr == 2'd2)) |=> noise_f);

    // R3: a disabled interrupt stays low.
    a_r3_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !en_noise |-> !irq_noise);
endmodule

bind rx_flag_unit rxf_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_noise  (ev_noise),
    .ev_break  (ev_break),
    .ev_start  (ev_start),
    .ev_false  (ev_false),
    .ev_idle   (ev_idle),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .noise_f   (noise_f),
    .frame_f   (frame_f),
    .full_f    (full_f),
    .rip_q     (rip_q),
    .en_noise  (en_noise),
    .irq_noise (irq_noise)
);

// File: tb/sim_rx_flag_unit.sv
// Bench: behavioural reference model compared every clock, plus directed reads.
module sim_rx_flag_unit;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ev = '0;   // 0 noise,1 frame,2 parity,3 break,4 ready,5 start,6 false,7 idle
    logic       line_high = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_in9 = 1'b0, mode9 = 1'b0;
    logic       en_noise = 1'b0, en_frame = 1'b0, en_parity = 1'b0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata, tx_data;
    logic       rx_bit9, irq_noise, irq_frame, irq_parity;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_flag_unit u0 (
        .clk(clk), .rst_n(rst_n),
        .ev_noise(ev[0]), .ev_frame(ev[1]), .ev_parity(ev[2]), .ev_break(ev[3]),
        .ev_ready(ev[4]), .ev_start(ev[5]), .ev_false(ev[6]), .ev_idle(ev[7]),
        .line_high(line_high), .rx_data(rx_data), .rx_in9(rx_in9), .mode9(mode9),
        .en_noise(en_noise), .en_frame(en_frame), .en_parity(en_parity),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .tx_data(tx_data), .rx_bit9(rx_bit9),
        .irq_noise(irq_noise), .irq_frame(irq_frame), .irq_parity(irq_parity)
    );

    // Reference model state: m_f[0] parity, [1] frame, [2] noise, [3] full
    bit [3:0] m_f = '0, m_arm = '0;
    bit       m_brk = 0, m_brk_arm = 0, m_blk = 0, m_rip = 0, m_b9 = 0;
    bit [7:0] m_buf = '0, m_tx = '0;
    bit       m_tx_ok = 0;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Model update on each rising edge, from the inputs held since the last falling edge.
    always @(posedge clk) begin
        bit [3:0] set;
        bit snap_a, snap_b, drd;
        set    = {ev[4] | ev[3], ev[0], ev[1] | ev[3], ev[2]};
        snap_a = bus_rd && bus_addr == 2'd0;
        snap_b = bus_rd && bus_addr == 2'd1;
        drd    = bus_rd && bus_addr == 2'd2;
        if (ev[4]) m_buf <= rx_data;
        if (bus_wr && bus_addr == 2'd2) begin m_tx <= bus_wdata; m_tx_ok <= 1; end
        if (!rst_n) begin
            m_f <= '0; m_arm <= '0; m_brk <= 0; m_brk_arm <= 0;
            m_blk <= 0; m_rip <= 0; m_b9 <= 0;
        end else begin
            for (int i = 0; i < 4; i++) begin
                if (set[i]) m_f[i] <= 1;
                else if (drd && m_arm[i]) m_f[i] <= 0;
                if (snap_a) m_arm[i] <= m_f[i];
                else if (drd) m_arm[i] <= 0;
            end
            if (ev[3] && !m_blk) m_brk <= 1;
            else if (drd && m_brk_arm) m_brk <= 0;
            if (snap_b) m_brk_arm <= m_brk;
            else if (drd) m_brk_arm <= 0;
            if (ev[3]) m_blk <= 1;
            else if (line_high) m_blk <= 0;
            if (ev[5]) m_rip <= 1;
            else if (ev[6] || ev[7]) m_rip <= 0;
            if (ev[4]) m_b9 <= rx_in9;
            else if (ev[3] && mode9) m_b9 <= 0;
        end
    end

    // Per-cycle comparison a quarter period after the edge.
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        check("R3 irq_noise",  irq_noise,  m_f[2] & en_noise);
        check("R3 irq_frame",  irq_frame,  m_f[1] & en_frame);
        check("R3 irq_parity", irq_parity, m_f[0] & en_parity);
        check("R7 rx_bit9",    rx_bit9,    m_b9);
        if (m_tx_ok) check("R10 tx_data", tx_data, m_tx);
    end

    function automatic bit [7:0] exp_read(input bit [1:0] a);
        case (a)
            2'd0:    return {2'b0, m_f[3], 2'b0, m_f[2], m_f[1], m_f[0]};
            2'd1:    return {6'b0, m_brk, m_rip};
            2'd2:    return m_buf;
            default: return 8'h00;
        endcase
    endfunction

    // One bus cycle with optional events; idle state is restored at the next call.
    task automatic cyc(input bit [7:0] e, input bit rd = 0, input bit [1:0] a = 0);
        @(negedge clk);
        ev = e; bus_rd = rd; bus_addr = a; bus_wr = 0;
    endtask

    // Peek a register without a read strobe (no side effect) and compare to the model.
    task automatic peek(input string req, input bit [1:0] a);
        @(negedge clk);
        ev = '0; bus_rd = 0; bus_wr = 0; bus_addr = a; line_high = 0;
        #1 check(req, bus_rdata, exp_read(a));
    endtask

    // Read with strobe and compare the returned value.
    task automatic rd(input string req, input bit [1:0] a, input bit [7:0] e = '0);
        @(negedge clk);
        ev = e; bus_rd = 1; bus_wr = 0; bus_addr = a;
        #1 check(req, bus_rdata, exp_read(a));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        peek("R1 status A after reset", 2'd0);
        check("R1 status A zero", bus_rdata, 8'h00);
        peek("R1 status B after reset", 2'd1);
        check("R1 status B zero", bus_rdata, 8'h00);
        check("R1 irq low", {irq_noise, irq_frame, irq_parity}, 0);

        // R10 / R2: byte arrives; data read without status read keeps flags (R4)
        @(negedge clk); rx_data = 8'hA5; rx_in9 = 1;
        cyc(8'h10);
        peek("R2 full flag", 2'd0);
        check("R2 full bit5", bus_rdata, 8'h20);
        rd("R10 data byte", 2'd2);
        check("R10 data A5", bus_rdata, 8'hA5);
        peek("R4 no clear without status read", 2'd0);
        check("R4 full kept", bus_rdata, 8'h20);

        // R2 / R3: error events with mixed enables
        @(negedge clk); en_noise = 1; en_parity = 0; en_frame = 1;
        cyc(8'h01); cyc(8'h02); cyc(8'h04);
        peek("R2 all error flags", 2'd0);
        check("R2 status A layout", bus_rdata, 8'h27);
        check("R3 parity gated off", irq_parity, 0);
        @(negedge clk); en_parity = 1;
        @(negedge clk);
        check("R3 parity enabled", irq_parity, 1);

        // R4: status read then data read clears all
        rd("R4 status read", 2'd0);
        rd("R4 data read", 2'd2);
        peek("R4 cleared", 2'd0);
        check("R4 status A clear", bus_rdata, 8'h00);

        // R5: event between status read and data read survives
        cyc(8'h04);
        rd("R5 status read", 2'd0);
        cyc(8'h01);
        rd("R5 data read", 2'd2);
        peek("R5 noise kept", 2'd0);
        check("R5 noise only", bus_rdata, 8'h04);

        // R6: set and clear in the same cycle
        rd("R6 status read", 2'd0);
        rd("R6 data read with noise", 2'd2, 8'h01);
        peek("R6 set wins", 2'd0);
        check("R6 noise still set", bus_rdata, 8'h04);
        rd("R6 status", 2'd0); rd("R6 data", 2'd2);

        // R7: break in nine-bit mode, all enables off
        @(negedge clk); en_noise = 0; en_frame = 0; en_parity = 0; mode9 = 1;
        @(negedge clk);
        check("R7 ninth bit before break", rx_bit9, 1);
        cyc(8'h08);
        peek("R7 break status B", 2'd1);
        check("R7 break bit1", bus_rdata, 8'h02);
        peek("R7 break status A", 2'd0);
        check("R7 frame and full", bus_rdata, 8'h22);
        check("R7 ninth bit cleared", rx_bit9, 0);
        check("R7 no irq", {irq_noise, irq_frame, irq_parity}, 0);

        // R11: clear break via status B then data
        rd("R11 status B", 2'd1);
        rd("R11 data", 2'd2);
        peek("R11 break cleared", 2'd1);
        check("R11 status B", bus_rdata, 8'h00);

        // R8: break without idle-high line is ignored
        cyc(8'h08);
        peek("R8 blocked break", 2'd1);
        check("R8 break stays clear", bus_rdata, 8'h00);
        @(negedge clk); line_high = 1;
        @(negedge clk); line_high = 0;
        cyc(8'h08);
        peek("R8 re-armed break", 2'd1);
        check("R8 break set again", bus_rdata, 8'h02);
        rd("R8 s", 2'd1); rd("R8 d", 2'd2);

        // R9: reception in progress
        cyc(8'h20);
        peek("R9 start", 2'd1);
        check("R9 rip set", bus_rdata, 8'h01);
        rd("R9 read no effect", 2'd1); rd("R9 data", 2'd2);
        peek("R9 rip after reads", 2'd1);
        check("R9 rip unchanged", bus_rdata, 8'h01);
        cyc(8'h40);
        peek("R9 false start", 2'd1);
        check("R9 rip cleared", bus_rdata, 8'h00);
        cyc(8'h20); cyc(8'h80);
        peek("R9 idle", 2'd1);
        check("R9 rip idle clear", bus_rdata, 8'h00);
        peek("R2 addr3", 2'd3);
        check("R2 addr3 zero", bus_rdata, 8'h00);

        // R10: write tx, then reset keeps data and tx
        @(negedge clk); rx_data = 8'h3C; rx_in9 = 0;
        cyc(8'h10); cyc(8'h01);
        @(negedge clk); ev = '0; bus_wr = 1; bus_addr = 2'd2; bus_wdata = 8'h96;
        @(negedge clk); bus_wr = 0;
        check("R10 tx written", tx_data, 8'h96);
        rst_n = 0;
        @(negedge clk); @(negedge clk); rst_n = 1;
        peek("R10 data after reset", 2'd2);
        check("R10 data kept", bus_rdata, 8'h3C);
        check("R10 tx kept", tx_data, 8'h96);
        peek("R1 flags after reset", 2'd0);
        check("R1 status A cleared", bus_rdata, 8'h00);

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule